// File: doc/BRIEF.md
# Tag Command Frame Assembler

This block turns a parallel downlink request for a low-frequency read/write tag into the serial bit sequence that a gap modulator then keys onto the carrier. A request carries a control byte, a 32-bit data word, a 32-bit password and an 8-bit block code. The control byte selects the downlink mode, page, test opcode, password use and read or write. The block decides which fields go into the frame and in what order. It adds the reference and fixed zero bits that some modes need. It then sends the frame one bit at a time, most significant bit first, on a valid/ready stream. The final bit carries a last marker.

A request is taken only when no frame is being sent. The frame is captured at that moment, so the caller may change its inputs while the bits go out. The downstream modulator may stall the stream at any bit. The long reference pulse of one mode and all pulse timing are left to the modulator.

Top module: `tagcmd_frame_asm`

## Requirements
- R1: Control byte fields: bit 0 enables the password, bit 1 is the page, bit 2 selects test mode, bits 4:3 give the downlink mode (0 fixed, 1 long reference, 2 leading zero, 3 one-of-four), bit 5 selects regular read and bit 6 marks a read.
- R2: In mode 2 the frame opens with one 0 reference bit. In mode 3 it opens with two 0 bits. Modes 0 and 1 add no reference bit.
- R3: The two opcode bits follow the reference bits. They are 1 then the page bit in normal operation, and 0 then 1 in test mode.
- R4: With the password enabled, the 32 password bits follow the opcode. In modes 2 and 3 two fixed 0 bits come first, and the other modes add none.
- R5: A lock bit of 0 always follows. The 32 data bits come after it only when the read flag is clear.
- R6: The 3 address bits (block code bits 2:0) end the frame unless regular read is in force. Regular read is in force when bit 5 is set, or for a read whose block code is 0xFF.
- R7: In mode 3 the frame length is even. An otherwise odd frame gets one trailing 0.
- R8: Exactly one bit per frame carries the last marker, and it is the final bit. A frame never exceeds 80 bits.
- R9: A request is taken only while no frame is in progress (req_ready high). The captured frame does not change when the inputs change after acceptance.
- R10: While the stream is stalled (bit_valid high, bit_ready low), bit_data and bit_last hold.
- R11: After reset, req_ready is high and bit_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_ctrl | input | 8 | Control byte |
| req_data | input | 32 | Data word for a write |
| req_pwd | input | 32 | Password |
| req_blk | input | 8 | Block code |
| bit_valid | output | 1 | Serial bit available |
| bit_ready | input | 1 | Modulator takes the bit |
| bit_data | output | 1 | Current frame bit |
| bit_last | output | 1 | Current bit is the final one of the frame |

## Verification
Two events can fall in the same cycle: the handshake of the final bit of a frame, and a new request that is already held valid. The bench keeps the next request asserted throughout the current frame. It requires req_ready to stay low for every bit of that frame. The second request must be taken only after the last bit has gone, and its frame must then arrive intact after the first one. Stalls at random-looking bits, and scrambling of the inputs right after acceptance, show that the captured frame and the bit currently shown do not drift.

// File: rtl/tagcmd_pkg.sv
package tagcmd_pkg;

  localparam int TC_CTRL_W = 8;
  localparam int TC_ADDR_W = 3;

  typedef enum logic [1:0] {
    DL_FIXED   = 2'd0,
    DL_LONGREF = 2'd1,
    DL_LEADZ   = 2'd2,
    DL_QUAD    = 2'd3
  } dl_mode_e;

  typedef struct packed {
    logic                 pwd_en;
    logic                 page;
    logic                 test;
    dl_mode_e             mode;
    logic                 reg_rd;
    logic                 rd;
    logic [TC_ADDR_W-1:0] addr;
  } tc_req_t;

endpackage

// File: rtl/tagcmd_ctrl_decode.sv
module tagcmd_ctrl_decode
  import tagcmd_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic [TC_CTRL_W-1:0] ctrl_i,
  input  logic [BLK_W-1:0]     blk_i,
  output tc_req_t              req_o
);

  logic blk_all_ones;

  always_comb begin
    blk_all_ones  = &blk_i;
    req_o.pwd_en  = ctrl_i[0];
    req_o.page    = ctrl_i[1];
    req_o.test    = ctrl_i[2];
    req_o.mode    = dl_mode_e'(ctrl_i[4:3]);
    req_o.rd      = ctrl_i[6];
    req_o.reg_rd  = ctrl_i[5] | (ctrl_i[6] & blk_all_ones);
    req_o.addr    = blk_i[TC_ADDR_W-1:0];
  end

endmodule

// File: rtl/tagcmd_frame_build.sv
module tagcmd_frame_build
  import tagcmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PWD_W    = 32,
  parameter int MAX_BITS = 80,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input  tc_req_t              req_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [PWD_W-1:0]     pwd_i,
  output logic [MAX_BITS-1:0]  frame_o,
  output logic [CW-1:0]        len_o
);

  logic [MAX_BITS-1:0] acc;
  logic [CW-1:0]       len;
  logic [1:0]          opcode;
  logic                ref_mode;

  always_comb begin
    ref_mode = (req_i.mode == DL_LEADZ) || (req_i.mode == DL_QUAD);
    opcode   = req_i.test ? 2'b01 : {1'b1, req_i.page};
    acc      = '0;
    len      = '0;
    // reference bits
    if (ref_mode) begin
      acc = acc << 1;
      len = len + CW'(1);
    end
    if (req_i.mode == DL_QUAD) begin
      acc = acc << 1;
      len = len + CW'(1);
    end
    // opcode
    acc = (acc << 2) | MAX_BITS'(opcode);
    len = len + CW'(2);
    // password with optional fixed zeros
    if (req_i.pwd_en) begin
      if (ref_mode) begin
        acc = acc << 2;
        len = len + CW'(2);
      end
      acc = (acc << PWD_W) | MAX_BITS'(pwd_i);
      len = len + CW'(PWD_W);
    end
    // lock bit
    acc = acc << 1;
    len = len + CW'(1);
    // data on write
    if (!req_i.rd) begin
      acc = (acc << DATA_W) | MAX_BITS'(data_i);
      len = len + CW'(DATA_W);
    end
    // address unless regular read
    if (!req_i.reg_rd) begin
      acc = (acc << TC_ADDR_W) | MAX_BITS'(req_i.addr);
      len = len + CW'(TC_ADDR_W);
    end
    // pair padding
    if ((req_i.mode == DL_QUAD) && len[0]) begin
      acc = acc << 1;
      len = len + CW'(1);
    end
    frame_o = acc << (CW'(MAX_BITS) - len);
    len_o   = len;
  end

endmodule

// File: rtl/tagcmd_serializer.sv
module tagcmd_serializer #(
  parameter int MAX_BITS = 80,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] frame_i,
  input  logic [CW-1:0]       len_i,
  output logic                idle_o,
  output logic                valid_o,
  input  logic                ready_i,
  output logic                data_o,
  output logic                last_o
);

  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic [CW-1:0]       rem_q, rem_d;
  logic                fire, en;

  always_comb begin
    valid_o = (rem_q != '0);
    idle_o  = (rem_q == '0);
    data_o  = sh_q[MAX_BITS-1];
    last_o  = (rem_q == CW'(1));
    fire    = valid_o & ready_i;
    en      = load_i | fire;
    sh_d    = sh_q;
    rem_d   = rem_q;
    if (load_i) begin
      sh_d  = frame_i;
      rem_d = len_i;
    end else if (fire) begin
      sh_d  = sh_q << 1;
      rem_d = rem_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/tagcmd_frame_asm.sv
module tagcmd_frame_asm
  import tagcmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PWD_W    = 32,
  parameter int BLK_W    = 8,
  parameter int MAX_BITS = 80,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [TC_CTRL_W-1:0] req_ctrl,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [PWD_W-1:0]     req_pwd,
  input  logic [BLK_W-1:0]     req_blk,
  output logic                 bit_valid,
  input  logic                 bit_ready,
  output logic                 bit_data,
  output logic                 bit_last
);

  logic [1:0]          rst_sync_q;
  tc_req_t             dec;
  logic [MAX_BITS-1:0] frame;
  logic [CW-1:0]       len;
  logic                idle, accept;

  // reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  tagcmd_ctrl_decode #(.BLK_W(BLK_W)) u_dec (
    .ctrl_i (req_ctrl),
    .blk_i  (req_blk),
    .req_o  (dec)
  );

  tagcmd_frame_build #(
    .DATA_W   (DATA_W),
    .PWD_W    (PWD_W),
    .MAX_BITS (MAX_BITS)
  ) u_build (
    .req_i   (dec),
    .data_i  (req_data),
    .pwd_i   (req_pwd),
    .frame_o (frame),
    .len_o   (len)
  );

  always_comb begin
    req_ready = idle & rst_sync_q[1];
    accept    = req_valid & req_ready;
  end

  tagcmd_serializer #(.MAX_BITS(MAX_BITS)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .frame_i (frame),
    .len_i   (len),
    .idle_o  (idle),
    .valid_o (bit_valid),
    .ready_i (bit_ready),
    .data_o  (bit_data),
    .last_o  (bit_last)
  );

endmodule

// File: rtl/tagcmd_frame_asm_chk.sv
module tagcmd_frame_asm_chk #(
  parameter int MAX_BITS = 80,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_ctrl,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic       bit_data,
  input logic       bit_last
);

  logic [CW-1:0] sent_q;
  logic [1:0]    mode_q;
  logic          take, fire;

  always_comb begin
    take = req_valid & req_ready;
    fire = bit_valid & bit_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      mode_q <= 2'd0;
    end else if (take) begin
      sent_q <= '0;
      mode_q <= req_ctrl[4:3];
    end else if (fire) begin
      sent_q <= sent_q + CW'(1);
    end
  end

  // R10: stalled bit holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data) && $stable(bit_last)));

  // R9: accepted request starts a frame and closes the request side
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (bit_valid && !req_ready));

  // R8: after the last bit the stream goes quiet and requests reopen
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bit_last) |=> (!bit_valid && req_ready));

  // R8: frame length cap
  p_len_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (sent_q < CW'(MAX_BITS)));

  // R7: one-of-four frames end on an even count
  p_even_pairs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bit_last && mode_q == 2'd3) |-> sent_q[0]);

  // R2: reference modes open with a zero
  p_first_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && sent_q == '0 && mode_q[1]) |-> !bit_data);

endmodule

bind tagcmd_frame_asm tagcmd_frame_asm_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ctrl  (req_ctrl),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .bit_data  (bit_data),
  .bit_last  (bit_last)
);

// File: tb/tagcmd_frame_asm_test.sv
module tagcmd_frame_asm_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_ctrl;
  logic [31:0] req_data;
  logic [31:0] req_pwd;
  logic [7:0]  req_blk;
  logic        bit_valid;
  logic        bit_ready;
  logic        bit_data;
  logic        bit_last;

  int checks   = 0;
  int failures = 0;
  bit exp_q[$];
  bit got_q[$];
  int last_cnt, last_idx, stable_bad, ready_bad;

  tagcmd_frame_asm uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_ctrl  (req_ctrl),
    .req_data  (req_data),
    .req_pwd   (req_pwd),
    .req_blk   (req_blk),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .bit_data  (bit_data),
    .bit_last  (bit_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_exp(input logic [7:0] c, input logic [31:0] d,
                           input logic [31:0] p, input logic [7:0] b);
    int  mode;
    bit  rd, rr;
    mode = int'(c[4:3]);
    rd   = c[6];
    rr   = c[5] || (rd && b == 8'hFF);
    exp_q.delete();
    if (mode >= 2) exp_q.push_back(1'b0);
    if (mode == 3) exp_q.push_back(1'b0);
    if (c[2]) begin exp_q.push_back(1'b0); exp_q.push_back(1'b1); end
    else      begin exp_q.push_back(1'b1); exp_q.push_back(c[1]); end
    if (c[0]) begin
      if (mode >= 2) begin exp_q.push_back(1'b0); exp_q.push_back(1'b0); end
      for (int i = 31; i >= 0; i--) exp_q.push_back(p[i]);
    end
    exp_q.push_back(1'b0);
    if (!rd) for (int i = 31; i >= 0; i--) exp_q.push_back(d[i]);
    if (!rr) for (int i = 2; i >= 0; i--) exp_q.push_back(b[i]);
    if (mode == 3 && (exp_q.size() % 2) == 1) exp_q.push_back(1'b0);
  endtask

  // drive a request at a negedge; it is taken at the following posedge
  task automatic send(input logic [7:0] c, input logic [31:0] d,
                      input logic [31:0] p, input logic [7:0] b, input bit scramble);
    @(negedge clk);
    req_ctrl  = c;
    req_data  = d;
    req_pwd   = p;
    req_blk   = b;
    req_valid = 1'b1;
    check(req_ready === 1'b1, "R9", "ready when idle", longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      req_ctrl = ~c;
      req_data = ~d;
      req_pwd  = ~p;
      req_blk  = ~b;
    end
  endtask

  task automatic collect(input bit stall);
    int  cyc;
    bit  done, prev_stalled, prev_d, prev_l;
    got_q.delete();
    last_cnt = 0; last_idx = -1; stable_bad = 0; ready_bad = 0;
    done = 0; cyc = 0; prev_stalled = 0; prev_d = 0; prev_l = 0;
    while (!done && cyc < 3000) begin
      if (prev_stalled && (!bit_valid || bit_data !== prev_d || bit_last !== prev_l))
        stable_bad++;
      if (bit_valid && req_ready) ready_bad++;
      bit_ready = stall ? (((cyc * 7) % 5) < 2) : 1'b1;
      if (bit_valid && bit_ready) begin
        got_q.push_back(bit_data);
        if (bit_last) begin
          last_cnt++;
          last_idx = got_q.size() - 1;
          done = 1;
        end
      end
      prev_stalled = bit_valid && !bit_ready;
      prev_d = bit_data;
      prev_l = bit_last;
      cyc++;
      @(negedge clk);
    end
    bit_ready = 1'b1;
  endtask

  task automatic compare(input string req);
    int first_bad;
    first_bad = -1;
    check(got_q.size() == exp_q.size(), req, "frame length",
          longint'(got_q.size()), longint'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (first_bad < 0 && got_q[i] != exp_q[i]) first_bad = i;
    check(first_bad < 0, req, "first mismatching bit index", longint'(first_bad), -1);
    check(last_cnt == 1 && last_idx == exp_q.size() - 1, "R8", "last marker position",
          longint'(last_idx), longint'(exp_q.size() - 1));
  endtask

  task automatic run_frame(input string req, input logic [7:0] c, input logic [31:0] d,
                           input logic [31:0] p, input logic [7:0] b, input bit stall);
    build_exp(c, d, p, b);
    send(c, d, p, b, 1'b1);
    collect(stall);
    compare(req);
    check(ready_bad == 0, "R9", "req_ready during frame", longint'(ready_bad), 0);
    if (stall)
      check(stable_bad == 0, "R10", "stall hold violations", longint'(stable_bad), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready === 1'b1 && bit_valid === 1'b0, "R11", "reset state",
          longint'({req_ready, bit_valid}), 2);
  endtask

  task automatic t_fixed_write;    // R1 R3 R5 R6: page 1, no password
    run_frame("R3", 8'h02, 32'hA5C3_0F01, 32'h0, 8'h05, 1'b0);
  endtask

  task automatic t_longref_pwd;    // R4: no fixed zeros in mode 1
    run_frame("R4", 8'h09, 32'h1234_5678, 32'hDEAD_BEEF, 8'h02, 1'b1);
  endtask

  task automatic t_leadzero_pwd;   // R2 R4 with stalls
    run_frame("R2", 8'h11, 32'hF0F0_1E2D, 32'h8000_0001, 8'h07, 1'b1);
  endtask

  task automatic t_quad_write;     // R2 R7: even without padding
    run_frame("R7", 8'h19, 32'h0BAD_CAFE, 32'h5555_AAAA, 8'h06, 1'b0);
  endtask

  task automatic t_quad_padded;    // R7: 5 bits padded to 6
    run_frame("R7", 8'h78, 32'hFFFF_FFFF, 32'h0, 8'h01, 1'b1);
  endtask

  task automatic t_test_opcode;    // R3: test opcode 01, read with address
    run_frame("R3", 8'h46, 32'h7777_7777, 32'h0, 8'h03, 1'b0);
  endtask

  task automatic t_read_ff;        // R6: read with 0xFF drops address
    run_frame("R6", 8'h50, 32'h1111_2222, 32'h0, 8'hFF, 1'b0);
  endtask

  task automatic t_write_ff;       // R6: write with 0xFF keeps address 111
    run_frame("R6", 8'h10, 32'h0000_0003, 32'h0, 8'hFF, 1'b0);
  endtask

  task automatic t_read_pwd_fixed; // R1 R5: read with password, mode 0
    run_frame("R1", 8'h43, 32'hABCD_EF01, 32'hC001_D00D, 8'h04, 1'b1);
  endtask

  // R9: next request held valid across the final bit of the current one
  task automatic t_back_to_back;
    logic [7:0]  c2;
    logic [31:0] d2, p2;
    logic [7:0]  b2;
    c2 = 8'h1B; d2 = 32'h2468_ACE0; p2 = 32'h1357_9BDF; b2 = 8'h01;
    build_exp(8'h00, 32'hCAFE_F00D, 32'h0, 8'h02);
    send(8'h00, 32'hCAFE_F00D, 32'h0, 8'h02, 1'b0);
    req_ctrl = c2; req_data = d2; req_pwd = p2; req_blk = b2;
    req_valid = 1'b1;
    collect(1'b0);
    compare("R9");
    check(ready_bad == 0, "R9", "held request not taken mid-frame", longint'(ready_bad), 0);
    check(req_ready === 1'b1, "R9", "ready right after last bit", longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_ctrl = ~c2; req_data = ~d2; req_pwd = ~p2; req_blk = ~b2;
    build_exp(c2, d2, p2, b2);
    collect(1'b1);
    compare("R9");
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_ctrl  = '0;
    req_data  = '0;
    req_pwd   = '0;
    req_blk   = '0;
    bit_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0 && bit_valid === 1'b0, "R11", "state in reset",
          longint'({req_ready, bit_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_fixed_write;
    t_longref_pwd;
    t_leadzero_pwd;
    t_quad_write;
    t_quad_padded;
    t_test_opcode;
    t_read_ff;
    t_write_ff;
    t_read_pwd_fixed;
    t_back_to_back;
    repeat (4) @(negedge clk);
    check(bit_valid === 1'b0 && req_ready === 1'b1, "R8", "quiet after final frame",
          longint'({bit_valid, req_ready}), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule